// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry-Out

This block is the shift stage of a processor datapath. It takes a 32-bit operand and shifts it left by a logical amount or rotates it right. The amount is an 8-bit unsigned value, as read from the low byte of a register. The block returns the shifted value, the carry that the shift produces, and a write strobe for that carry. Downstream flag logic uses the strobe to decide whether to commit the new carry. Every amount from 0 to 255 gives the exact result, including 0, 32 and everything above 32.

Both shift paths are computed in parallel as logarithmic barrel stages, and the operation select chooses between them. The three outputs are registered once. Results therefore appear one clock after the inputs are presented, and reset clears them to zero.

Top module: `shrot_unit`

## Requirements
- R1: With op_sel = 0 (left shift) and 1 <= amount <= 31, result bit i equals operand bit i-amount for i >= amount, and is 0 for i < amount.
- R2: With op_sel = 0 and 1 <= amount <= 32, carry_out equals operand bit 32-amount.
- R3: With amount = 0, for either operation, result equals the operand, carry_out equals carry_in and carry_we is 0.
- R4: With op_sel = 0 and amount >= 32, result is all zero.
- R5: With op_sel = 0 and amount >= 33, carry_out is 0.
- R6: With op_sel = 1 (rotate right) and 1 <= amount <= 31, result bit i equals operand bit (i+amount) mod 32, and carry_out equals operand bit amount-1.
- R7: With op_sel = 1 and amount a nonzero multiple of 32, result equals the operand and carry_out equals operand bit 31.
- R8: With op_sel = 1 and amount > 32, result and carry_out equal those of a rotate by amount mod 32, where a remainder of 0 follows R7.
- R9: carry_we is 1 for every nonzero amount, for both operations.
- R10: All outputs are registered one clock after the inputs are sampled. While rst_n is low, the outputs are cleared to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| operand | input | 32 | Value to shift or rotate |
| amount | input | 8 | Unsigned shift or rotate count |
| op_sel | input | 1 | 0 = logical shift left, 1 = rotate right |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value, registered |
| carry_out | output | 1 | New carry value, registered |
| carry_we | output | 1 | Carry write strobe, registered |

## Verification
The assertions compare the registered outputs against the inputs seen one edge earlier. For this to be valid, every input must hold a known value at each sampled edge. The assertions are also gated by a flag that marks one full cycle out of reset, because the first post-reset output still reflects the cleared state. The bench sets all inputs before releasing reset and changes them only on falling edges. It walks all 256 amounts for both operations over several operand patterns, so the comparisons always see stable, defined inputs.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic {
    OP_LSL = 1'b0,
    OP_ROR = 1'b1
  } shrot_op_e;

  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned AMT_W_DEF  = 8;
endpackage

// File: rtl/shrot_lsl.sv
module shrot_lsl #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             we
);
  localparam int unsigned IDX_W = $clog2(WIDTH);
  localparam int unsigned STG   = IDX_W + 1;

  // extended vector: bit WIDTH catches the last bit shifted out
  logic [WIDTH:0] stg [STG+1];
  logic           far_out;
  logic [WIDTH:0] ext;

  assign stg[0] = {1'b0, opnd};

  generate
    for (genvar k = 0; k < STG; k++) begin : g_stage
      assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
    end
  endgenerate

  assign far_out = |amt[AMT_W-1:STG];
  assign ext     = far_out ? '0 : stg[STG];

  always_comb begin
    we   = |amt;
    res  = ext[WIDTH-1:0];
    cout = we ? ext[WIDTH] : cin;
  end
endmodule

// File: rtl/shrot_ror.sv
module shrot_ror #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             we
);
  localparam int unsigned IDX_W = $clog2(WIDTH);

  function automatic logic [WIDTH-1:0] rotr_by(input logic [WIDTH-1:0] v, input int unsigned s);
    return (v >> s) | (v << (WIDTH - s));
  endfunction

  logic [WIDTH-1:0] stg [IDX_W+1];

  assign stg[0] = opnd;

  // only amount mod WIDTH matters for the rotated value
  generate
    for (genvar k = 0; k < IDX_W; k++) begin : g_stage
      assign stg[k+1] = amt[k] ? rotr_by(stg[k], 1 << k) : stg[k];
    end
  endgenerate

  always_comb begin
    we   = |amt;
    res  = stg[IDX_W];
    // last bit rotated lands in the top position, also for multiples of WIDTH
    cout = we ? stg[IDX_W][WIDTH-1] : cin;
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W_DEF,
  parameter int unsigned AMT_W = AMT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  logic             op_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             carry_we
);
  shrot_op_e        op;
  logic [WIDTH-1:0] lsl_res, ror_res, sel_res;
  logic             lsl_c, ror_c, lsl_we, ror_we, sel_c, sel_we;
  logic             primed;

  assign op = shrot_op_e'(op_sel);

  shrot_lsl #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_lsl (
    .opnd(operand), .amt(amount), .cin(carry_in),
    .res(lsl_res), .cout(lsl_c), .we(lsl_we)
  );

  shrot_ror #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_ror (
    .opnd(operand), .amt(amount), .cin(carry_in),
    .res(ror_res), .cout(ror_c), .we(ror_we)
  );

  always_comb begin
    if (op == OP_ROR) begin
      sel_res = ror_res; sel_c = ror_c; sel_we = ror_we;
    end else begin
      sel_res = lsl_res; sel_c = lsl_c; sel_we = lsl_we;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
      carry_we  <= 1'b0;
      primed    <= 1'b0;
    end else begin
      result    <= sel_res;
      carry_out <= sel_c;
      carry_we  <= sel_we;
      primed    <= 1'b1;
    end
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !carry_out && !carry_we));

  assert_zero_amount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(amount) == '0) |->
      (result == $past(operand) && carry_out == $past(carry_in) && !carry_we));

  assert_strobe_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (carry_we == ($past(amount) != '0)));

  assert_lsl_wide_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(op_sel) && $past(amount) >= AMT_W'(WIDTH)) |-> (result == '0));

  assert_lsl_far_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(op_sel) && $past(amount) > AMT_W'(WIDTH)) |-> !carry_out);

  assert_ror_carry_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) && carry_we) |-> (carry_out == result[WIDTH-1]));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic        op_sel = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out, carry_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .amount(amount),
    .op_sel(op_sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .carry_we(carry_we)
  );

  // behavioural reference, bit by bit with integers
  function automatic logic [33:0] model(input logic [31:0] a, input int n, input bit rot, input bit ci);
    logic [31:0] r;
    logic c;
    for (int i = 0; i < 32; i++) begin
      if (rot) r[i] = a[(i + n) % 32];
      else     r[i] = (i - n >= 0) ? a[i - n] : 1'b0;
    end
    if (n == 0)      c = ci;
    else if (rot)    c = a[(n - 1) % 32];
    else if (n <= 32) c = a[32 - n];
    else             c = 1'b0;
    return {c, (n != 0), r};
  endfunction

  function automatic string tag(input bit rot, input int n);
    if (n == 0) return "R3";
    if (!rot) begin
      if (n < 32)  return "R1 R2 R9";
      if (n == 32) return "R2 R4 R9";
      return "R4 R5 R9";
    end
    if (n < 32)      return "R6 R9";
    if (n % 32 == 0) return "R7 R8 R9";
    return "R8 R9";
  endfunction

  task automatic compare(input logic [33:0] exp, input string req);
    checks++;
    if ({carry_out, carry_we, result} !== exp) begin
      errors++;
      $display("FAIL %s: got c=%0b we=%0b r=%h expected c=%0b we=%0b r=%h",
               req, carry_out, carry_we, result, exp[33], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF; pats[2] = 32'h0000_0001;
    pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5A5_5A5A;
    operand = 32'hFFFF_FFFF; carry_in = 1'b1; amount = 8'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(34'h0, "R10");
    rst_n = 1'b1;
    for (int p = 0; p < 5; p++) begin
      for (int o = 0; o < 2; o++) begin
        for (int n = 0; n < 256; n++) begin
          @(negedge clk);
          operand  = pats[p];
          amount   = 8'(n);
          op_sel   = o[0];
          carry_in = (n % 3 == 1);
          @(negedge clk);
          compare(model(pats[p], n, o[0], (n % 3 == 1)), tag(o[0], n));
        end
      end
    end
    // back-to-back edges: one-cycle latency
    @(negedge clk);
    operand = 32'h1234_5678; amount = 8'd4; op_sel = 1'b0; carry_in = 1'b0;
    @(negedge clk);
    operand = 32'h0F00_0000; amount = 8'd36; op_sel = 1'b1;
    compare(model(32'h1234_5678, 4, 1'b0, 1'b0), "R10 R1");
    @(negedge clk);
    compare(model(32'h0F00_0000, 36, 1'b1, 1'b0), "R10 R8");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule